// File: doc/BRIEF.md
# Dual-Bank Frame Granule Interleaver

This block sits between the frame movers of a packet buffer and two independent synchronous SRAM banks, each with its own data bus that is one granule (eight bytes by default) wide. A frame arrives as a stream of granules marked with start and end flags and a count of valid bytes in the end granule. The block sends the granules of each frame to the two banks in turn, always beginning on bank A. Each pair of granules shares one word address, found by adding half the granule index to the frame's base address. Because each bank accepts one operation per tick, a frame writer uses one bank in a tick and leaves the other bank free for the read engine.

The read engine takes a base address and a granule count. It fetches the frame in the same order, bank A first, and returns the granules in order with a marker on the last one. Lookup-table writes have top priority. Each one goes to both banks in the same tick with the same address and data, so that a later lookup can be served by whichever bank is free. While a table write is present, the frame writer is held off through its ready signal, so no granule is lost.

A frame that ends with a granule on bank A leaves the next bank B slot unused, because the next frame starts on bank A again. With a 1-byte end granule this costs at most 15 byte slots per frame. That is less than the 20-byte gap between frames, so back-to-back frames cannot overrun.

Top module: `granule_interleaver`

## Requirements
- R1: The first granule of a frame is written to bank A at the base address given with start-of-frame. Later granules alternate between B and A, and granule k is written at base + k/2 (integer division).
- R2: A new frame always starts on bank A, even when the previous frame's last granule also went to bank A. The bank B slot between the two frames stays unused.
- R3: A granule that is not an end granule is written with all eight byte enables set (0xFF). An end granule with a count n from 1 to 8 enables the n lowest bytes (bit i of the enables selects data bits 8i+7:8i). A count of 0 or above 8 is treated as 8.
- R4: While `tbl_valid` is high, both banks receive a write in the following tick, with address `tbl_addr`, data `tbl_data` and all bytes enabled. In that tick `wr_ready` is low, and a held frame granule is written once `tbl_valid` falls.
- R5: A granule accepted without start-of-frame while no frame is open is not written to either bank, and `wr_err` is high in the following tick.
- R6: A start-of-frame accepted while a frame is still open raises `wr_err` in the following tick. The new frame starts on bank A at its own base address.
- R7: A pulse on `rd_start` with a nonzero `rd_len` while `rd_busy` is low sets `rd_busy`. It then issues reads for granules 0 to `rd_len`-1 at the same banks and addresses as R1, and returns the granules in order on `rd_data` with `rd_dlast` high on the last one only. `rd_busy` is low again after the last read has been issued.
- R8: A read waits while its bank is taken by a frame write or a table write in the same tick. It never changes the order, and the waiting causes no loss or duplication.
- R9: During and right after reset, no bank is enabled, `wr_err`, `rd_busy` and `rd_dvalid` are low, and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Frame granule present |
| wr_ready | output | 1 | Granule accepted this tick |
| wr_sof | input | 1 | First granule of a frame |
| wr_eof | input | 1 | Last granule of a frame |
| wr_nbytes | input | 4 | Valid bytes in the end granule (1 to 8) |
| wr_base | input | AW | Word base address, taken with start-of-frame |
| wr_data | input | DW | Granule data |
| wr_err | output | 1 | Framing error seen in the previous tick |
| tbl_valid | input | 1 | Mirrored table write request |
| tbl_addr | input | AW | Table word address |
| tbl_data | input | DW | Table data |
| rd_start | input | 1 | Start a frame fetch |
| rd_base | input | AW | Fetch base address |
| rd_len | input | LW | Fetch length in granules |
| rd_busy | output | 1 | Fetch still issuing |
| rd_dvalid | output | 1 | Returned granule present |
| rd_data | output | DW | Returned granule |
| rd_dlast | output | 1 | Returned granule is the frame's last |
| bank_a_en | output | 1 | Bank A operation enable |
| bank_a_we | output | 1 | Bank A write (else read) |
| bank_a_addr | output | AW | Bank A word address |
| bank_a_be | output | DW/8 | Bank A byte enables |
| bank_a_wdata | output | DW | Bank A write data |
| bank_a_rdata | input | DW | Bank A read data, RD_LAT ticks after the request |
| bank_b_en | output | 1 | Bank B operation enable |
| bank_b_we | output | 1 | Bank B write (else read) |
| bank_b_addr | output | AW | Bank B word address |
| bank_b_be | output | DW/8 | Bank B byte enables |
| bank_b_wdata | output | DW | Bank B write data |
| bank_b_rdata | input | DW | Bank B read data |

## Verification
A granule or table write accepted at a clock edge shows on the bank pins right after that edge. `wr_err` follows on the same edge. The bench therefore drives each vector just after a falling edge and checks the bank pins at the next falling edge. A fetch started at edge E raises `rd_busy` after E and puts its first read on the pins after E+1. Each returned granule appears RD_LAT+1 edges after its read was issued. The bench checks the order of the reads on the pins cycle by cycle, and collects the returned granules with a falling-edge monitor so that their order and end marker are compared regardless of stalls.

// File: rtl/gi_pkg.sv
// Shared types for the dual-bank granule interleaver.
// Assumes exactly two banks; bank A is encoded as 0, bank B as 1.
package gi_pkg;
    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    // One entry of the read-return tag pipeline.
    typedef struct packed {
        logic v;
        logic bank;
        logic last;
    } rd_tag_t;
endpackage

// File: rtl/gi_wr_steer.sv
// Frame write steering: picks the bank, word address and byte enables for
// each incoming granule and tracks whether a frame is open.
// Assumes one granule per tick at most and that hold (a mirrored table
// write) stalls the stream through wr_ready.
module gi_wr_steer #(
    parameter int AW = 10,
    parameter int DW = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    input  logic                 wr_sof,
    input  logic                 wr_eof,
    input  logic [$clog2(DW/8):0] wr_nbytes,
    input  logic [AW-1:0]        wr_base,
    input  logic                 hold,
    output logic                 wr_ready,
    output logic                 frame_open,
    output logic                 req,
    output logic                 req_bank,
    output logic [AW-1:0]        req_addr,
    output logic [DW/8-1:0]      req_be,
    output logic                 wr_err
);
    import gi_pkg::*;

    localparam int BW = DW / 8;
    localparam int IW = AW + 1;

    logic          open_q;
    logic [AW-1:0] base_q;
    logic [IW-1:0] idx_q;
    logic [IW-1:0] idx_now;
    logic [AW-1:0] base_now;
    logic          fire;
    logic          bad_start;
    logic          restart;
    logic [BW-1:0] tail_be;

    // Handshake: stall only while a table write owns both banks.
    always_comb begin
        wr_ready  = ~hold;
        fire      = wr_valid & ~hold;
        bad_start = fire & ~wr_sof & ~open_q;
        restart   = fire & wr_sof & open_q;
        req       = fire & (wr_sof | open_q);
    end

    // Position of this granule inside its frame; a start always resets it.
    always_comb begin
        idx_now  = wr_sof ? '0 : idx_q;
        base_now = wr_sof ? wr_base : base_q;
        req_bank = idx_now[0];
        req_addr = base_now + AW'(idx_now >> 1);
    end

    // Byte enables: low bytes first on the end granule, out-of-range = full.
    always_comb begin
        if (wr_nbytes == '0 || int'(wr_nbytes) > BW)
            tail_be = '1;
        else
            tail_be = BW'({BW{1'b1}} >> (BW - int'(wr_nbytes)));
        req_be = wr_eof ? tail_be : '1;
    end

    // Frame state and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            base_q <= '0;
            idx_q  <= '0;
            wr_err <= 1'b0;
        end else begin
            wr_err <= bad_start | restart;
            if (req) begin
                open_q <= ~wr_eof;
                base_q <= base_now;
                idx_q  <= idx_now + 1'b1;
            end
        end
    end

    assign frame_open = open_q;
endmodule

// File: rtl/gi_rd_fetch.sv
// Frame read engine: issues one granule read per tick in A/B order,
// waiting whenever the needed bank is taken by higher-priority traffic,
// and returns read data in order through a tag pipeline.
// Assumes bank read data is valid RD_LAT ticks after the request is on
// the bank pins, and that the bank pins are registered one tick after req.
module gi_rd_fetch #(
    parameter int AW     = 10,
    parameter int DW     = 64,
    parameter int LW     = 8,
    parameter int RD_LAT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_start,
    input  logic [AW-1:0] rd_base,
    input  logic [LW-1:0] rd_len,
    input  logic          taken_a,
    input  logic          taken_b,
    input  logic [DW-1:0] rdata_a,
    input  logic [DW-1:0] rdata_b,
    output logic          rd_busy,
    output logic          req,
    output logic          req_bank,
    output logic [AW-1:0] req_addr,
    output logic          rd_dvalid,
    output logic [DW-1:0] rd_data,
    output logic          rd_dlast
);
    import gi_pkg::*;

    logic          busy_q;
    logic [AW-1:0] base_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] idx_q;
    logic          last;
    logic          blocked;
    rd_tag_t       tag_q [RD_LAT+1];

    // Issue decision for the current granule.
    always_comb begin
        req_bank = idx_q[0];
        req_addr = base_q + AW'(idx_q >> 1);
        blocked  = (req_bank == BANK_B) ? taken_b : taken_a;
        last     = (idx_q == len_q - 1'b1);
        req      = busy_q & ~blocked;
    end

    // Fetch sequencing: accept a start when idle, step on each issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            base_q <= '0;
            len_q  <= '0;
            idx_q  <= '0;
        end else if (!busy_q) begin
            if (rd_start && rd_len != '0) begin
                busy_q <= 1'b1;
                base_q <= rd_base;
                len_q  <= rd_len;
                idx_q  <= '0;
            end
        end else if (req) begin
            idx_q <= idx_q + 1'b1;
            if (last)
                busy_q <= 1'b0;
        end
    end

    // Tag pipeline aligned with the bank pin register and SRAM latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k <= RD_LAT; k++)
                tag_q[k] <= '0;
        end else begin
            tag_q[0] <= '{v: req, bank: req_bank, last: last};
            for (int k = 1; k <= RD_LAT; k++)
                tag_q[k] <= tag_q[k-1];
        end
    end

    // Return stage: pick the bank named by the tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_dvalid <= 1'b0;
            rd_data   <= '0;
            rd_dlast  <= 1'b0;
        end else begin
            rd_dvalid <= tag_q[RD_LAT].v;
            rd_data   <= tag_q[RD_LAT].bank ? rdata_b : rdata_a;
            rd_dlast  <= tag_q[RD_LAT].v & tag_q[RD_LAT].last;
        end
    end

    assign rd_busy = busy_q;
endmodule

// File: rtl/gi_bank_port.sv
// One bank's pin register: merges table, frame-write and read requests with
// fixed priority table > write > read and drives the bank pins one tick later.
// Assumes the caller never issues a read to a bank it reports as taken.
module gi_bank_port #(
    parameter int AW      = 10,
    parameter int DW      = 64,
    parameter int BANK_ID = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tbl_valid,
    input  logic [AW-1:0]   tbl_addr,
    input  logic [DW-1:0]   tbl_data,
    input  logic            wr_req,
    input  logic            wr_bank,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [DW/8-1:0] wr_be,
    input  logic            rd_req,
    input  logic            rd_bank,
    input  logic [AW-1:0]   rd_addr,
    output logic            en,
    output logic            we,
    output logic [AW-1:0]   addr,
    output logic [DW/8-1:0] be,
    output logic [DW-1:0]   wdata
);
    localparam logic ME = BANK_ID[0];

    logic hit_wr;
    logic hit_rd;

    // Which sources address this bank in the current tick.
    always_comb begin
        hit_wr = wr_req & (wr_bank == ME);
        hit_rd = rd_req & (rd_bank == ME);
    end

    // Pin register with fixed priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en    <= 1'b0;
            we    <= 1'b0;
            addr  <= '0;
            be    <= '0;
            wdata <= '0;
        end else if (tbl_valid) begin
            en    <= 1'b1;
            we    <= 1'b1;
            addr  <= tbl_addr;
            be    <= '1;
            wdata <= tbl_data;
        end else if (hit_wr) begin
            en    <= 1'b1;
            we    <= 1'b1;
            addr  <= wr_addr;
            be    <= wr_be;
            wdata <= wr_data;
        end else if (hit_rd) begin
            en    <= 1'b1;
            we    <= 1'b0;
            addr  <= rd_addr;
            be    <= '0;
            wdata <= '0;
        end else begin
            en    <= 1'b0;
            we    <= 1'b0;
            be    <= '0;
        end
    end

    // R8
    // one_source_chk: a read is never granted while this bank is otherwise taken
    bank_one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_rd |-> !(tbl_valid || hit_wr));
endmodule

// File: rtl/granule_interleaver.sv
// Dual-bank frame granule interleaver top: frame writes alternate A/B from
// bank A at every frame start, table writes are mirrored into both banks,
// and a read engine fetches frames back in the same order.
// Assumes synchronous SRAM banks with read data RD_LAT ticks after request.
module granule_interleaver #(
    parameter int AW     = 10,
    parameter int DW     = 64,
    parameter int LW     = 8,
    parameter int RD_LAT = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    output logic                 wr_ready,
    input  logic                 wr_sof,
    input  logic                 wr_eof,
    input  logic [$clog2(DW/8):0] wr_nbytes,
    input  logic [AW-1:0]        wr_base,
    input  logic [DW-1:0]        wr_data,
    output logic                 wr_err,
    input  logic                 tbl_valid,
    input  logic [AW-1:0]        tbl_addr,
    input  logic [DW-1:0]        tbl_data,
    input  logic                 rd_start,
    input  logic [AW-1:0]        rd_base,
    input  logic [LW-1:0]        rd_len,
    output logic                 rd_busy,
    output logic                 rd_dvalid,
    output logic [DW-1:0]        rd_data,
    output logic                 rd_dlast,
    output logic                 bank_a_en,
    output logic                 bank_a_we,
    output logic [AW-1:0]        bank_a_addr,
    output logic [DW/8-1:0]      bank_a_be,
    output logic [DW-1:0]        bank_a_wdata,
    input  logic [DW-1:0]        bank_a_rdata,
    output logic                 bank_b_en,
    output logic                 bank_b_we,
    output logic [AW-1:0]        bank_b_addr,
    output logic [DW/8-1:0]      bank_b_be,
    output logic [DW-1:0]        bank_b_wdata,
    input  logic [DW-1:0]        bank_b_rdata
);
    import gi_pkg::*;

    localparam int BW     = DW / 8;
    localparam int NBANKS = 2;

    logic            w_req;
    logic            w_bank;
    logic [AW-1:0]   w_addr;
    logic [BW-1:0]   w_be;
    logic            frame_open;
    logic            r_req;
    logic            r_bank;
    logic [AW-1:0]   r_addr;
    logic            taken_a;
    logic            taken_b;

    logic            p_en    [NBANKS];
    logic            p_we    [NBANKS];
    logic [AW-1:0]   p_addr  [NBANKS];
    logic [BW-1:0]   p_be    [NBANKS];
    logic [DW-1:0]   p_wdata [NBANKS];

    gi_wr_steer #(.AW(AW), .DW(DW)) u_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_sof     (wr_sof),
        .wr_eof     (wr_eof),
        .wr_nbytes  (wr_nbytes),
        .wr_base    (wr_base),
        .hold       (tbl_valid),
        .wr_ready   (wr_ready),
        .frame_open (frame_open),
        .req        (w_req),
        .req_bank   (w_bank),
        .req_addr   (w_addr),
        .req_be     (w_be),
        .wr_err     (wr_err)
    );

    // Banks claimed ahead of the read engine in this tick.
    always_comb begin
        taken_a = tbl_valid | (w_req & (w_bank == BANK_A));
        taken_b = tbl_valid | (w_req & (w_bank == BANK_B));
    end

    gi_rd_fetch #(.AW(AW), .DW(DW), .LW(LW), .RD_LAT(RD_LAT)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_start  (rd_start),
        .rd_base   (rd_base),
        .rd_len    (rd_len),
        .taken_a   (taken_a),
        .taken_b   (taken_b),
        .rdata_a   (bank_a_rdata),
        .rdata_b   (bank_b_rdata),
        .rd_busy   (rd_busy),
        .req       (r_req),
        .req_bank  (r_bank),
        .req_addr  (r_addr),
        .rd_dvalid (rd_dvalid),
        .rd_data   (rd_data),
        .rd_dlast  (rd_dlast)
    );

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        gi_bank_port #(.AW(AW), .DW(DW), .BANK_ID(b)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .tbl_valid (tbl_valid),
            .tbl_addr  (tbl_addr),
            .tbl_data  (tbl_data),
            .wr_req    (w_req),
            .wr_bank   (w_bank),
            .wr_addr   (w_addr),
            .wr_data   (wr_data),
            .wr_be     (w_be),
            .rd_req    (r_req),
            .rd_bank   (r_bank),
            .rd_addr   (r_addr),
            .en        (p_en[b]),
            .we        (p_we[b]),
            .addr      (p_addr[b]),
            .be        (p_be[b]),
            .wdata     (p_wdata[b])
        );
    end

    // Pin mapping of the two bank ports.
    assign bank_a_en    = p_en[0];
    assign bank_a_we    = p_we[0];
    assign bank_a_addr  = p_addr[0];
    assign bank_a_be    = p_be[0];
    assign bank_a_wdata = p_wdata[0];
    assign bank_b_en    = p_en[1];
    assign bank_b_we    = p_we[1];
    assign bank_b_addr  = p_addr[1];
    assign bank_b_be    = p_be[1];
    assign bank_b_wdata = p_wdata[1];

    // R4
    // tbl_mirror_chk: a table write lands identically in both banks
    tbl_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && tbl_valid) |->
            bank_a_en && bank_a_we && bank_b_en && bank_b_we &&
            bank_a_addr == $past(tbl_addr) && bank_b_addr == $past(tbl_addr) &&
            bank_a_wdata == $past(tbl_data) && bank_b_wdata == $past(tbl_data));

    // R1
    // sof_on_a_chk: every accepted frame start is written to bank A at its base
    sof_on_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && wr_valid && wr_ready && wr_sof) |->
            bank_a_en && bank_a_we && bank_a_addr == $past(wr_base));

    // R3
    // full_be_chk: a non-end granule of an open frame is written with all bytes
    full_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && wr_valid && wr_ready && !wr_eof && (wr_sof || frame_open)) |->
            (bank_a_en && bank_a_we && $countones(bank_a_be) == BW) ||
            (bank_b_en && bank_b_we && $countones(bank_b_be) == BW));

    // R5
    // orphan_err_chk: a granule with no open frame is flagged and not written
    orphan_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && wr_valid && wr_ready && !wr_sof && !frame_open) |->
            wr_err && !(bank_a_en && bank_a_we) && !(bank_b_en && bank_b_we));

    // R7
    // rd_accept_chk: an accepted fetch start raises busy
    rd_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && rd_start && !rd_busy && rd_len != '0) |-> rd_busy);
endmodule

// File: tb/granule_interleaver_tb.sv
module granule_interleaver_tb;
    localparam int CLK_P  = 10;
    localparam int AW     = 6;
    localparam int DW     = 64;
    localparam int LW     = 4;
    localparam int RD_LAT = 1;
    localparam int DEPTH  = 1 << AW;

    typedef struct packed {
        logic       sof;
        logic       eof;
        logic [3:0] nb;
        logic [5:0] base;
        logic       exb;
        logic [5:0] exa;
        logic [7:0] exbe;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 4'd8, 6'd4,  1'b0, 6'd4,  8'hFF},
        '{1'b0, 1'b0, 4'd8, 6'd0,  1'b1, 6'd4,  8'hFF},
        '{1'b0, 1'b0, 4'd8, 6'd0,  1'b0, 6'd5,  8'hFF},
        '{1'b0, 1'b1, 4'd1, 6'd0,  1'b1, 6'd5,  8'h01},
        '{1'b1, 1'b1, 4'd3, 6'd10, 1'b0, 6'd10, 8'h07},
        '{1'b1, 1'b0, 4'd8, 6'd20, 1'b0, 6'd20, 8'hFF},
        '{1'b0, 1'b0, 4'd8, 6'd0,  1'b1, 6'd20, 8'hFF},
        '{1'b0, 1'b1, 4'd1, 6'd0,  1'b0, 6'd21, 8'h01},
        '{1'b1, 1'b0, 4'd8, 6'd30, 1'b0, 6'd30, 8'hFF},
        '{1'b0, 1'b1, 4'd0, 6'd0,  1'b1, 6'd30, 8'hFF},
        '{1'b1, 1'b1, 4'd9, 6'd40, 1'b0, 6'd40, 8'hFF}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0, wr_sof = 1'b0, wr_eof = 1'b0;
    logic [3:0]    wr_nbytes = '0;
    logic [AW-1:0] wr_base = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready, wr_err;
    logic          tbl_valid = 1'b0;
    logic [AW-1:0] tbl_addr = '0;
    logic [DW-1:0] tbl_data = '0;
    logic          rd_start = 1'b0;
    logic [AW-1:0] rd_base = '0;
    logic [LW-1:0] rd_len = '0;
    logic          rd_busy, rd_dvalid, rd_dlast;
    logic [DW-1:0] rd_data;
    logic          bank_a_en, bank_a_we, bank_b_en, bank_b_we;
    logic [AW-1:0] bank_a_addr, bank_b_addr;
    logic [7:0]    bank_a_be, bank_b_be;
    logic [DW-1:0] bank_a_wdata, bank_b_wdata;
    logic [DW-1:0] bank_a_rdata, bank_b_rdata;

    int n_chk = 0;
    int n_err = 0;

    logic [DW-1:0] mem_a [DEPTH];
    logic [DW-1:0] mem_b [DEPTH];
    logic [DW-1:0] cap_d [16];
    logic          cap_l [16];
    int            cap_n = 0;

    always #(CLK_P/2) clk = ~clk;

    granule_interleaver #(.AW(AW), .DW(DW), .LW(LW), .RD_LAT(RD_LAT)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sof(wr_sof), .wr_eof(wr_eof),
        .wr_nbytes(wr_nbytes), .wr_base(wr_base), .wr_data(wr_data), .wr_err(wr_err),
        .tbl_valid(tbl_valid), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .rd_start(rd_start), .rd_base(rd_base), .rd_len(rd_len), .rd_busy(rd_busy),
        .rd_dvalid(rd_dvalid), .rd_data(rd_data), .rd_dlast(rd_dlast),
        .bank_a_en(bank_a_en), .bank_a_we(bank_a_we), .bank_a_addr(bank_a_addr),
        .bank_a_be(bank_a_be), .bank_a_wdata(bank_a_wdata), .bank_a_rdata(bank_a_rdata),
        .bank_b_en(bank_b_en), .bank_b_we(bank_b_we), .bank_b_addr(bank_b_addr),
        .bank_b_be(bank_b_be), .bank_b_wdata(bank_b_wdata), .bank_b_rdata(bank_b_rdata)
    );

    // SRAM bank models: one-tick read latency, byte-enabled writes.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_a[i] <= '0;
                mem_b[i] <= '0;
            end
        end else begin
            if (bank_a_en && bank_a_we) begin
                for (int k = 0; k < 8; k++)
                    if (bank_a_be[k]) mem_a[bank_a_addr][8*k +: 8] <= bank_a_wdata[8*k +: 8];
            end else if (bank_a_en) begin
                bank_a_rdata <= mem_a[bank_a_addr];
            end
            if (bank_b_en && bank_b_we) begin
                for (int k = 0; k < 8; k++)
                    if (bank_b_be[k]) mem_b[bank_b_addr][8*k +: 8] <= bank_b_wdata[8*k +: 8];
            end else if (bank_b_en) begin
                bank_b_rdata <= mem_b[bank_b_addr];
            end
        end
    end

    // Collects returned read granules in arrival order.
    always @(negedge clk) begin
        if (rd_dvalid && cap_n < 16) begin
            cap_d[cap_n] <= rd_data;
            cap_l[cap_n] <= rd_dlast;
            cap_n <= cap_n + 1;
        end
    end

    function automatic logic [DW-1:0] gdata(input int i);
        return {8'(i) + 8'h10, 48'h0123_4567_89AB, 8'(i) + 8'h80};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_wr(input logic sof, input logic eof, input logic [3:0] nb,
                            input logic [AW-1:0] base, input logic [DW-1:0] d);
        wr_valid = 1'b1; wr_sof = sof; wr_eof = eof; wr_nbytes = nb; wr_base = base; wr_data = d;
    endtask

    task automatic idle_wr;
        wr_valid = 1'b0; wr_sof = 1'b0; wr_eof = 1'b0;
    endtask

    initial begin
        int c0;
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(!bank_a_en && !bank_b_en, "R9 bank enables in reset", {62'd0, bank_a_en, bank_b_en}, 0);
        chk(!wr_err && !rd_busy && !rd_dvalid && wr_ready, "R9 status in reset",
            {60'd0, wr_err, rd_busy, rd_dvalid, wr_ready}, 64'h1);
        rst_n = 1'b1;
        tick();
        chk(!bank_a_en && !bank_b_en && !wr_err, "R9 after reset", {61'd0, bank_a_en, bank_b_en, wr_err}, 0);

        // R1 R2 R3: vector table of frame granules
        for (int i = 0; i < NV; i++) begin
            drive_wr(VEC[i].sof, VEC[i].eof, VEC[i].nb, VEC[i].base, gdata(i));
            tick();
            if (VEC[i].exb == 1'b0) begin
                chk(bank_a_en && bank_a_we && !bank_b_en, $sformatf("R1 R2 bank A vec %0d", i),
                    {62'd0, bank_a_en & bank_a_we, bank_b_en}, 64'h2);
                chk(bank_a_addr == VEC[i].exa, $sformatf("R1 addr vec %0d", i), 64'(bank_a_addr), 64'(VEC[i].exa));
                chk(bank_a_be == VEC[i].exbe, $sformatf("R3 be vec %0d", i), 64'(bank_a_be), 64'(VEC[i].exbe));
                chk(bank_a_wdata == gdata(i), $sformatf("R1 data vec %0d", i), bank_a_wdata, gdata(i));
            end else begin
                chk(bank_b_en && bank_b_we && !bank_a_en, $sformatf("R1 bank B vec %0d", i),
                    {62'd0, bank_b_en & bank_b_we, bank_a_en}, 64'h2);
                chk(bank_b_addr == VEC[i].exa, $sformatf("R1 addr vec %0d", i), 64'(bank_b_addr), 64'(VEC[i].exa));
                chk(bank_b_be == VEC[i].exbe, $sformatf("R3 be vec %0d", i), 64'(bank_b_be), 64'(VEC[i].exbe));
                chk(bank_b_wdata == gdata(i), $sformatf("R1 data vec %0d", i), bank_b_wdata, gdata(i));
            end
            chk(!wr_err, $sformatf("R5 no error vec %0d", i), 64'(wr_err), 0);
        end
        idle_wr();

        // R4: mirrored table write stalls a pending frame granule
        tbl_valid = 1'b1; tbl_addr = 6'd33; tbl_data = 64'hFACE_0000_1234_5678;
        drive_wr(1'b1, 1'b1, 4'd8, 6'd50, gdata(50));
        #1;
        chk(!wr_ready, "R4 wr_ready low during table write", 64'(wr_ready), 0);
        tick();
        chk(bank_a_en && bank_a_we && bank_b_en && bank_b_we, "R4 both banks written",
            {60'd0, bank_a_en, bank_a_we, bank_b_en, bank_b_we}, 64'hF);
        chk(bank_a_addr == 6'd33 && bank_b_addr == 6'd33, "R4 mirrored address",
            {52'd0, bank_a_addr, bank_b_addr}, {52'd0, 6'd33, 6'd33});
        chk(bank_a_wdata == tbl_data && bank_b_wdata == tbl_data, "R4 mirrored data", bank_b_wdata, tbl_data);
        tbl_valid = 1'b0;
        tick();
        chk(bank_a_en && bank_a_we && bank_a_addr == 6'd50 && bank_a_wdata == gdata(50),
            "R4 held granule written after table write", bank_a_wdata, gdata(50));
        idle_wr();
        tick();

        // R5: granule without start while no frame is open
        drive_wr(1'b0, 1'b0, 4'd8, 6'd7, gdata(60));
        tick();
        chk(wr_err == 1'b1, "R5 orphan granule flagged", 64'(wr_err), 1);
        chk(!(bank_a_en && bank_a_we) && !(bank_b_en && bank_b_we), "R5 orphan granule not written",
            {62'd0, bank_a_en & bank_a_we, bank_b_en & bank_b_we}, 0);
        idle_wr();
        tick();
        chk(wr_err == 1'b0, "R5 error is one tick", 64'(wr_err), 0);

        // R6: start while a frame is open
        drive_wr(1'b1, 1'b0, 4'd8, 6'd44, gdata(61));
        tick();
        drive_wr(1'b1, 1'b0, 4'd8, 6'd52, gdata(62));
        tick();
        chk(wr_err == 1'b1, "R6 restart flagged", 64'(wr_err), 1);
        chk(bank_a_en && bank_a_we && bank_a_addr == 6'd52, "R6 restart on bank A at new base",
            64'(bank_a_addr), 64'd52);
        drive_wr(1'b0, 1'b1, 4'd2, 6'd0, gdata(63));
        tick();
        chk(bank_b_en && bank_b_we && bank_b_addr == 6'd52 && bank_b_be == 8'h03 && !wr_err,
            "R6 R3 second granule of restarted frame", {48'd0, bank_b_addr, 2'd0, bank_b_be}, {48'd0, 6'd52, 2'd0, 8'h03});
        idle_wr();
        tick();

        // R7: read back frame at base 20 (3 granules, 1-byte end on bank A)
        c0 = cap_n;
        rd_start = 1'b1; rd_base = 6'd20; rd_len = 4'd3;
        tick();
        rd_start = 1'b0;
        chk(rd_busy == 1'b1, "R7 busy after start", 64'(rd_busy), 1);
        tick();
        chk(bank_a_en && !bank_a_we && bank_a_addr == 6'd20 && !bank_b_en, "R7 first read on A",
            64'(bank_a_addr), 64'd20);
        tick();
        chk(bank_b_en && !bank_b_we && bank_b_addr == 6'd20 && !bank_a_en, "R7 second read on B",
            64'(bank_b_addr), 64'd20);
        tick();
        chk(bank_a_en && !bank_a_we && bank_a_addr == 6'd21, "R7 third read on A", 64'(bank_a_addr), 64'd21);
        chk(rd_busy == 1'b0, "R7 busy clears after last issue", 64'(rd_busy), 0);
        repeat (6) tick();
        chk(cap_n - c0 == 3, "R7 granule count", 64'(cap_n - c0), 3);
        chk(cap_d[c0] == gdata(5) && cap_d[c0+1] == gdata(6), "R7 data order", cap_d[c0+1], gdata(6));
        chk(cap_d[c0+2] == (gdata(7) & 64'hFF), "R7 partial end granule", cap_d[c0+2], gdata(7) & 64'hFF);
        chk(!cap_l[c0] && !cap_l[c0+1] && cap_l[c0+2], "R7 last marker",
            {61'd0, cap_l[c0], cap_l[c0+1], cap_l[c0+2]}, 64'h1);

        // R8: read of frame at base 4 competing with a frame write at base 58
        c0 = cap_n;
        rd_start = 1'b1; rd_base = 6'd4; rd_len = 4'd4;
        tick();
        rd_start = 1'b0;
        drive_wr(1'b1, 1'b0, 4'd8, 6'd58, gdata(70));
        tick();
        chk(bank_a_en && bank_a_we && bank_a_addr == 6'd58 && !bank_b_en, "R8 read waits for write on A",
            {62'd0, bank_a_we, bank_b_en}, 64'h2);
        drive_wr(1'b0, 1'b0, 4'd8, 6'd0, gdata(71));
        tick();
        chk(bank_a_en && !bank_a_we && bank_a_addr == 6'd4 && bank_b_we && bank_b_addr == 6'd58,
            "R8 read A beside write B", {52'd0, bank_a_addr, bank_b_addr}, {52'd0, 6'd4, 6'd58});
        drive_wr(1'b0, 1'b0, 4'd8, 6'd0, gdata(72));
        tick();
        chk(bank_b_en && !bank_b_we && bank_b_addr == 6'd4 && bank_a_we && bank_a_addr == 6'd59,
            "R8 read B beside write A", {52'd0, bank_b_addr, bank_a_addr}, {52'd0, 6'd4, 6'd59});
        drive_wr(1'b0, 1'b1, 4'd8, 6'd0, gdata(73));
        tick();
        idle_wr();
        repeat (8) tick();
        chk(cap_n - c0 == 4, "R8 granule count", 64'(cap_n - c0), 4);
        chk(cap_d[c0] == gdata(0) && cap_d[c0+1] == gdata(1) && cap_d[c0+2] == gdata(2),
            "R8 data order under stalls", cap_d[c0+2], gdata(2));
        chk(cap_d[c0+3] == (gdata(3) & 64'hFF) && cap_l[c0+3] && !cap_l[c0+2],
            "R8 R7 end granule and marker", cap_d[c0+3], gdata(3) & 64'hFF);
        chk(rd_busy == 1'b0, "R7 idle after fetch", 64'(rd_busy), 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_P * 50000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule